// File: doc/BRIEF.md
# Clock Control Register Bank

This block is a bank of 28 memory-mapped 32-bit words. It holds the configuration for the PLLs, the clock dividers, the clock gates and the power management. Software reaches the bank through a plain read/write port that carries a byte offset. Reads are registered and come back on the cycle after the request. An access that falls outside the bank, or that is not word aligned, is dropped. Such an access raises a one-cycle error pulse.

The bank also reports the frequencies, in hertz, of the core, the bus and the peripheral clock. It derives them from the live control word (word 2) and from the main-PLL frequency supplied on an input. The derivation is a fixed chain:

- the reference or the PLL is selected;
- an optional three-quarter scaling is applied;
- a 1+N core divider follows, then a 1+N bus divider;
- a final halving gives the peripheral clock.

A separate combinational lookup port takes a clock identifier and returns the matching frequency. It flags identifiers it does not know.

Top module: `clk_cfg_bank`

## Requirements
- R1: After reset, the words read as follows. Word 0 = 0x800B2C01, word 1 = 0x84042800, word 2 = 0xD0030000, word 3 = 0x028A0100, word 4 = 0x04008100, word 5 = 0x00000438. Words 6 to 9 = 0x01010101. Word 22 = 0x00A00000, words 23 and 24 = 0x0000A030, word 25 = 0x43000000. Every other word is zero.
- R2: A write at a word-aligned offset below 0x70 stores all 32 data bits in word offset/4, with no masking. A read of that offset returns the stored word on rdata one cycle after rd_en.
- R3: An access at offset 0x70 or above changes no word. A read there returns zero on rdata. bad_access pulses high on the cycle after either kind of access.
- R4: An access whose offset has bits [1:0] not equal to zero is treated as bad. It stores nothing, a read returns zero, and bad_access pulses on the next cycle. A valid access leaves bad_access low on the next cycle.
- R5: Control bit 22 selects the PLL frequency. When it is set, the PLL frequency is 24000000. When it is clear, the PLL frequency is pll_freq_in.
- R6: core_freq is formed in two steps. When control bit 14 is set, the PLL frequency is first replaced by PLL×3/4 (integer division). The result is then integer-divided by 1 + control bits [31:30].
- R7: bus_freq = core_freq / (1 + control bits [29:28]), using integer division. periph_freq = bus_freq / 2.
- R8: The lookup port maps identifiers as follows. Identifiers 1 and 2 return periph_freq. Identifier 3 returns 32768. Identifier 0 returns 0 with req_err low. Identifiers 4 to 7 return 0 with req_err high.
- R9: The frequency outputs reflect a new control word in the cycle after the write that stores it.
- R10: With the reset control word and pll_freq_in = 532000000, core_freq = 133000000, bus_freq = 66500000 and periph_freq = 33250000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after rd_en |
| bad_access | output | 1 | Pulse after an out-of-range or misaligned access |
| pll_freq_in | input | 32 | Main-PLL output frequency in Hz |
| req_id | input | 3 | Clock identifier for the lookup port |
| req_freq | output | 32 | Frequency for req_id |
| req_err | output | 1 | req_id is unsupported |
| core_freq | output | 32 | Core clock frequency in Hz |
| bus_freq | output | 32 | Bus clock frequency in Hz |
| periph_freq | output | 32 | Peripheral clock frequency in Hz |

## Verification
The assertions check the following on every cycle:

- the error pulse after bad or misaligned accesses, and its absence after valid ones;
- zero read data outside the bank;
- write-then-read return of the stored word;
- the ordering core ≥ bus ≥ peripheral;
- the lookup mapping for the none, peripheral and low-frequency identifiers.

Only the bench scenarios can show the rest:

- the exact reset contents of all 28 words;
- that dropped writes do not alias onto real words;
- the exact truncating arithmetic of the scaling and dividers for chosen control words and PLL inputs;
- the 133/66.5/33.25 MHz reset point.

// File: rtl/clk_cfg_bank.sv
module clk_cfg_bank #(
  parameter int ADDR_W    = 8,
  parameter int NUM_REGS  = 28,
  parameter int CTRL_IDX  = 2,
  parameter int REF_FREQ  = 24000000,
  parameter int SLOW_FREQ = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              bad_access,
  input  logic [31:0]       pll_freq_in,
  input  logic [2:0]        req_id,
  output logic [31:0]       req_freq,
  output logic              req_err,
  output logic [31:0]       core_freq,
  output logic [31:0]       bus_freq,
  output logic [31:0]       periph_freq
);
  localparam int IDX_W = $clog2(NUM_REGS);
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(NUM_REGS * 4);

  function automatic logic [31:0] reset_word(int i);
    case (i)
      0:               return 32'h800B2C01;
      1:               return 32'h84042800;
      2:               return 32'hD0030000;
      3:               return 32'h028A0100;
      4:               return 32'h04008100;
      5:               return 32'h00000438;
      6, 7, 8, 9:      return 32'h01010101;
      22:              return 32'h00A00000;
      23, 24:          return 32'h0000A030;
      25:              return 32'h43000000;
      default:         return 32'h0;
    endcase
  endfunction

  logic [31:0] regs [NUM_REGS];
  logic             acc_ok;
  logic [IDX_W-1:0] widx;

  assign acc_ok = (addr < LIMIT) && (addr[1:0] == 2'b00);
  assign widx   = addr[IDX_W+1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= reset_word(i);
      rdata      <= '0;
      bad_access <= 1'b0;
    end else begin
      if (wr_en && acc_ok) regs[widx] <= wdata;
      if (rd_en) rdata <= acc_ok ? regs[widx] : 32'h0;
      bad_access <= (wr_en || rd_en) && !acc_ok;
    end
  end

  logic [31:0] ctrl;
  logic [33:0] pll_f, scaled, core_w;

  assign ctrl   = regs[CTRL_IDX];
  assign pll_f  = ctrl[22] ? 34'(REF_FREQ) : {2'b00, pll_freq_in};
  assign scaled = ctrl[14] ? (pll_f * 34'd3) / 34'd4 : pll_f;
  assign core_w = scaled / (34'd1 + 34'(ctrl[31:30]));

  assign core_freq   = core_w[31:0];
  assign bus_freq    = core_freq / (32'd1 + 32'(ctrl[29:28]));
  assign periph_freq = {1'b0, bus_freq[31:1]};

  always_comb begin
    req_err  = 1'b0;
    req_freq = 32'h0;
    case (req_id)
      3'd0:       req_freq = 32'h0;
      3'd1, 3'd2: req_freq = periph_freq;
      3'd3:       req_freq = 32'(SLOW_FREQ);
      default:    req_err  = 1'b1;
    endcase
  end
endmodule

module clk_cfg_bank_chk #(
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 28
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic              bad_access,
  input logic [2:0]        req_id,
  input logic [31:0]       req_freq,
  input logic              req_err,
  input logic [31:0]       core_freq,
  input logic [31:0]       bus_freq,
  input logic [31:0]       periph_freq
);
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(NUM_REGS * 4);
  logic good;
  assign good = (addr < LIMIT) && (addr[1:0] == 2'b00);

  // R3
  oob_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en || rd_en) && addr >= LIMIT) |=> bad_access);
  // R3
  oob_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr >= LIMIT) |=> rdata == 32'h0);
  // R4
  misalign_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en || rd_en) && addr[1:0] != 2'b00) |=> bad_access);
  // R4
  good_no_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en || rd_en) && good) |=> !bad_access);
  // R2
  readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && rd_en && !wr_en && good && addr == $past(addr))
      |=> rdata == $past(wdata, 2));
  // R7
  freq_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_freq >= bus_freq && bus_freq >= periph_freq);
  // R8
  req_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_id == 3'd0 |-> (req_freq == 32'h0 && !req_err));
  // R8
  req_periph_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_id == 3'd1 || req_id == 3'd2) |-> (req_freq == periph_freq && !req_err));
  // R8
  req_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_id == 3'd3 |-> req_freq == 32'd32768);
endmodule

bind clk_cfg_bank clk_cfg_bank_chk #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .bad_access(bad_access), .req_id(req_id),
  .req_freq(req_freq), .req_err(req_err), .core_freq(core_freq),
  .bus_freq(bus_freq), .periph_freq(periph_freq)
);

// File: tb/test_clk_cfg_bank.sv
`timescale 1ns/1ps
module test_clk_cfg_bank;
  logic        clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0, pll_freq_in = 32'd532000000;
  logic [2:0]  req_id = 0;
  logic [31:0] rdata, req_freq, core_freq, bus_freq, periph_freq;
  logic        bad_access, req_err;

  int total = 0, bad = 0;
  logic [31:0] q_data[$];
  logic        q_chk[$], q_bad[$];
  string       q_tag[$];
  logic        seen = 0;

  always #2.5 clk = ~clk;

  clk_cfg_bank i_clk_cfg_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .bad_access(bad_access),
    .pll_freq_in(pll_freq_in), .req_id(req_id), .req_freq(req_freq),
    .req_err(req_err), .core_freq(core_freq), .bus_freq(bus_freq),
    .periph_freq(periph_freq));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rst_exp(int i);
    if (i == 0) return 32'h800B2C01;
    if (i == 1) return 32'h84042800;
    if (i == 2) return 32'hD0030000;
    if (i == 3) return 32'h028A0100;
    if (i == 4) return 32'h04008100;
    if (i == 5) return 32'h00000438;
    if (i >= 6 && i <= 9) return 32'h01010101;
    if (i == 22) return 32'h00A00000;
    if (i == 23 || i == 24) return 32'h0000A030;
    if (i == 25) return 32'h43000000;
    return 32'h0;
  endfunction

  function automatic logic [31:0] m_core(logic [31:0] c, logic [31:0] pll);
    longint p = c[22] ? 64'd24000000 : longint'(pll);
    if (c[14]) p = (p * 3) / 4;
    return 32'(p / (1 + c[31:30]));
  endfunction

  // driver: one access, expected outcome pushed to scoreboard
  task automatic acc(bit wr, bit rd, logic [7:0] a, logic [31:0] d,
                     bit chk, logic [31:0] exp, bit exp_bad, string tag);
    @(negedge clk);
    wr_en = wr; rd_en = rd; addr = a; wdata = d;
    q_data.push_back(exp); q_chk.push_back(chk);
    q_bad.push_back(exp_bad); q_tag.push_back(tag);
    @(negedge clk);
    wr_en = 0; rd_en = 0;
  endtask

  always @(posedge clk) seen <= wr_en | rd_en;

  // monitor
  always @(negedge clk) begin
    if (seen && q_data.size() > 0) begin
      logic [31:0] e; logic c, b; string t;
      e = q_data.pop_front(); c = q_chk.pop_front();
      b = q_bad.pop_front(); t = q_tag.pop_front();
      if (c) check({t, " rdata"}, rdata, e);
      check({t, " bad_access"}, {31'd0, bad_access}, {31'd0, b});
    end
  end

  task automatic freq_chk(string tag, logic [31:0] c, logic [31:0] pll);
    logic [31:0] ec = m_core(c, pll);
    logic [31:0] eb = ec / (1 + c[29:28]);
    check({tag, " core"}, core_freq, ec);
    check({tag, " bus"}, bus_freq, eb);
    check({tag, " periph"}, periph_freq, eb / 2);
  endtask

  task automatic req_chk(logic [2:0] id, logic [31:0] ef, bit ee);
    @(negedge clk);
    req_id = id;
    #1;
    check("R8 req_freq", req_freq, ef);
    check("R8 req_err", {31'd0, req_err}, {31'd0, ee});
  endtask

  task automatic ctrl_case(string tag, logic [31:0] c, logic [31:0] pll);
    pll_freq_in = pll;
    acc(1, 0, 8'h08, c, 0, 0, 0, tag);
    freq_chk(tag, c, pll);
  endtask

  initial begin
    #(5.0 * 20000);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R10 core", core_freq, 32'd133000000);
    check("R10 bus", bus_freq, 32'd66500000);
    check("R10 periph", periph_freq, 32'd33250000);
    for (int i = 0; i < 28; i++)
      acc(0, 1, 8'(i * 4), 0, 1, rst_exp(i), 0, "R1");

    req_chk(3'd0, 32'd0, 0);
    req_chk(3'd1, 32'd33250000, 0);
    req_chk(3'd2, 32'd33250000, 0);
    req_chk(3'd3, 32'd32768, 0);
    for (int id = 4; id < 8; id++) req_chk(3'(id), 32'd0, 1);

    acc(1, 0, 8'h28, 32'hDEADBEEF, 0, 0, 0, "R2");
    acc(0, 1, 8'h28, 0, 1, 32'hDEADBEEF, 0, "R2");
    acc(1, 0, 8'h6C, 32'hFFFFFFFF, 0, 0, 0, "R2");
    acc(0, 1, 8'h6C, 0, 1, 32'hFFFFFFFF, 0, "R2");

    acc(1, 0, 8'h70, 32'h12345678, 0, 0, 1, "R3");
    acc(0, 1, 8'h70, 0, 1, 32'h0, 1, "R3");
    acc(1, 0, 8'hB0, 32'hCAFEF00D, 0, 0, 1, "R3");
    acc(1, 0, 8'hA8, 32'h0BADF00D, 0, 0, 1, "R3");
    acc(0, 1, 8'h30, 0, 1, 32'h0, 0, "R3 alias");
    acc(0, 1, 8'h28, 0, 1, 32'hDEADBEEF, 0, "R3 alias");
    acc(0, 1, 8'hFC, 0, 1, 32'h0, 1, "R3");

    acc(1, 0, 8'h09, 32'h0, 0, 0, 1, "R4");
    acc(0, 1, 8'h09, 0, 1, 32'h0, 1, "R4");
    acc(0, 1, 8'h08, 0, 1, 32'hD0030000, 0, "R4");
    freq_chk("R4 freq", 32'hD0030000, 32'd532000000);

    ctrl_case("R9", 32'h00000000, 32'd532000000);
    ctrl_case("R5", 32'h00400000, 32'd532000000);
    check("R5 bypass core", core_freq, 32'd24000000);
    ctrl_case("R6", 32'h00404000, 32'd532000000);
    check("R6 scaled core", core_freq, 32'd18000000);
    ctrl_case("R6", 32'h80004000, 32'd100000001);
    ctrl_case("R7", 32'h40002000, 32'd100000003);
    ctrl_case("R7", 32'hF0000000, 32'd400000000);
    check("R7 bus div", bus_freq, 32'd25000000);
    req_chk(3'd1, 32'd12500000, 0);

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule